// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Status Controller

This block gathers interrupt events from two sources, a bus-phase group of sixteen event lines and a transfer-engine (DMA) group of eight event lines, and holds them until software has seen them. Each source has a visible first-level status set and a hidden second-level set behind it. While a source already has a pending summary bit, later events are stacked in the hidden set. When software reads the visible status, the first level is cleared and the stacked events move forward into view. Events are single-cycle pulses on the event inputs. Status reads are one-cycle read strobes, and a strobe clears the first level at the same clock edge. There is no streaming interface: every pin is plain control or status.

Each event bit is classed as fatal or nonfatal by a parameter map. A fatal event always raises the halt request and the source summary bit. A masked fatal event does not drive the interrupt pin. A masked nonfatal event is only posted in the visible status. It never stacks, never sets the summary bit and never requests an interrupt. The active-low interrupt request is held high for a fixed gap after every status read, so that software sees an edge before any promoted events reassert it.

Top module: `stk_irq_ctrl`

## Requirements
- R1: After reset all status outputs are zero, both summary bits are 0, `irq_n` is 1 and `halt_req` is 0.
- R2: An unmasked event that arrives while its source summary bit is 0 sets its visible status bit and the summary bit on the next clock edge. `irq_n` goes low at that edge unless a post-read gap is running.
- R3: A masked nonfatal event sets its visible status bit but leaves the summary bit at 0 and `irq_n` high. A later event on that source therefore goes directly into the visible status.
- R4: A fatal event raises `halt_req` on the next edge whether it is masked or not, and it sets the summary bit. A masked fatal event never pulls `irq_n` low. Default fatal map: DMA bits 0, 2 and 3 (0x0D); bus-phase bits 0, 1, 2, 8 and 9 (0x0307).
- R5: `halt_req` stays high until every fatal status bit, visible or stacked, has been cleared by reads.
- R6: Setting a mask bit while `irq_n` is low does not raise `irq_n`. Only a status read does.
- R7: While a source summary bit is 1 and no read of that source occurs, new fatal or unmasked events leave that source's visible status unchanged and go to the hidden level.
- R8: Further events while both levels are occupied are ORed into the hidden level, so none is lost.
- R9: A read strobe replaces the source's visible status with its hidden contents on that edge and empties the hidden level. The summary bit then shows whether any promoted event is pending.
- R10: After any read strobe, `irq_n` is 1 for GAP_CYCLES (default 3) cycles. It then goes low if a promoted unmasked event is pending.
- R11: A read strobe on either bus-phase register (`rd_scsi0` for bits 7:0, `rd_scsi1` for bits 15:8) clears both halves together.
- R12: An event that arrives in the same cycle as its source's read strobe joins the promoted set and is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scsi_evt | input | 2*REG_W | Bus-phase event pulses |
| scsi_mask | input | 2*REG_W | Bus-phase mask, 1 = masked |
| dma_evt | input | REG_W | Transfer-engine event pulses |
| dma_mask | input | REG_W | Transfer-engine mask, 1 = masked |
| rd_scsi0 | input | 1 | Read strobe, low bus-phase status register |
| rd_scsi1 | input | 1 | Read strobe, high bus-phase status register |
| rd_dma | input | 1 | Read strobe, transfer-engine status register |
| scsi_stat0 | output | REG_W | Visible bus-phase status, bits 7:0 |
| scsi_stat1 | output | REG_W | Visible bus-phase status, bits 15:8 |
| dma_stat | output | REG_W | Visible transfer-engine status |
| scsi_pend | output | 1 | Bus-phase summary pending bit |
| dma_pend | output | 1 | Transfer-engine summary pending bit |
| irq_n | output | 1 | Interrupt request, active low |
| halt_req | output | 1 | Halt request to the script engine |

## Verification
The bench builds the block with the default parameters: eight-bit registers, the fatal maps named in R4 and a three-cycle gap. With a three-cycle gap, the whole high window after a read and the reassertion that follows can be observed cycle by cycle. The fatal maps place masked and unmasked fatal bits next to nonfatal bits in the same register, so stacking, promotion with a coincident event and the release of the halt request can all be driven through one eight-bit source. The split sixteen-bit bus-phase source makes the shared clear by either strobe reachable.

// File: rtl/stk_irq_pkg.sv
package stk_irq_pkg;
  localparam int unsigned DEF_REG_W = 8;
  localparam int unsigned DEF_GAP   = 3;

  function automatic int unsigned cnt_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sis_level_pair.sv
module sis_level_pair #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] FATAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic         clr,
  output logic [W-1:0] stat,
  output logic         pend,
  output logic         req,
  output logic         fatal_hold
);
  logic [W-1:0] lvl1_q, lvl2_q, req1_q, req2_q;
  logic         pend_q;
  logic [W-1:0] sig, quiet, wake;

  // sig: events that count toward the summary bit (fatal or unmasked)
  assign sig   = evt & (FATAL | ~mask);
  // quiet: masked nonfatal events, posted only
  assign quiet = evt & ~FATAL & mask;
  // wake: events allowed to request an interrupt
  assign wake  = evt & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl1_q <= '0;
      lvl2_q <= '0;
      req1_q <= '0;
      req2_q <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      lvl1_q <= lvl2_q | evt;
      req1_q <= req2_q | wake;
      pend_q <= |(lvl2_q | sig);
      lvl2_q <= '0;
      req2_q <= '0;
    end else if (pend_q) begin
      lvl1_q <= lvl1_q | quiet;
      lvl2_q <= lvl2_q | sig;
      req2_q <= req2_q | wake;
    end else begin
      lvl1_q <= lvl1_q | evt;
      req1_q <= req1_q | wake;
      pend_q <= |sig;
    end
  end

  assign stat       = lvl1_q;
  assign pend       = pend_q;
  assign req        = |req1_q;
  assign fatal_hold = |((lvl1_q | lvl2_q) & FATAL);
endmodule

// File: rtl/sis_gap_timer.sv
module sis_gap_timer #(
  parameter int unsigned GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic open_win
);
  import stk_irq_pkg::*;
  localparam int unsigned CW = cnt_bits(GAP);

  generate
    if (GAP == 0) begin : g_none
      assign open_win = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CW'(GAP);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign open_win = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/stk_irq_ctrl.sv
module stk_irq_ctrl #(
  parameter int unsigned          REG_W      = stk_irq_pkg::DEF_REG_W,
  parameter logic [2*REG_W-1:0]   SCSI_FATAL = 16'h0307,
  parameter logic [REG_W-1:0]     DMA_FATAL  = 8'h0D,
  parameter int unsigned          GAP_CYCLES = stk_irq_pkg::DEF_GAP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*REG_W-1:0] scsi_evt,
  input  logic [2*REG_W-1:0] scsi_mask,
  input  logic [REG_W-1:0]   dma_evt,
  input  logic [REG_W-1:0]   dma_mask,
  input  logic               rd_scsi0,
  input  logic               rd_scsi1,
  input  logic               rd_dma,
  output logic [REG_W-1:0]   scsi_stat0,
  output logic [REG_W-1:0]   scsi_stat1,
  output logic [REG_W-1:0]   dma_stat,
  output logic               scsi_pend,
  output logic               dma_pend,
  output logic               irq_n,
  output logic               halt_req
);
  localparam int unsigned SW = 2 * REG_W;

  logic [SW-1:0] scsi_stat;
  logic          scsi_req, dma_req, scsi_fh, dma_fh, gap_open, any_rd;

  assign any_rd = rd_scsi0 | rd_scsi1 | rd_dma;

  sis_level_pair #(.W(SW), .FATAL(SCSI_FATAL)) u_scsi (
    .clk(clk), .rst_n(rst_n), .evt(scsi_evt), .mask(scsi_mask),
    .clr(rd_scsi0 | rd_scsi1), .stat(scsi_stat), .pend(scsi_pend),
    .req(scsi_req), .fatal_hold(scsi_fh)
  );

  sis_level_pair #(.W(REG_W), .FATAL(DMA_FATAL)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .mask(dma_mask),
    .clr(rd_dma), .stat(dma_stat), .pend(dma_pend),
    .req(dma_req), .fatal_hold(dma_fh)
  );

  sis_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(any_rd), .open_win(gap_open)
  );

  assign scsi_stat0 = scsi_stat[REG_W-1:0];
  assign scsi_stat1 = scsi_stat[SW-1:REG_W];
  assign irq_n      = !((scsi_req | dma_req) && gap_open);
  assign halt_req   = scsi_fh | dma_fh;
endmodule

// File: rtl/stk_irq_ctrl_chk.sv
module stk_irq_ctrl_chk #(
  parameter int unsigned        REG_W      = 8,
  parameter logic [2*REG_W-1:0] SCSI_FATAL = 16'h0307,
  parameter logic [REG_W-1:0]   DMA_FATAL  = 8'h0D,
  parameter int unsigned        GAP_CYCLES = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*REG_W-1:0] scsi_evt,
  input logic [2*REG_W-1:0] scsi_mask,
  input logic [REG_W-1:0]   dma_evt,
  input logic [REG_W-1:0]   dma_mask,
  input logic               rd_scsi0,
  input logic               rd_scsi1,
  input logic               rd_dma,
  input logic [REG_W-1:0]   scsi_stat0,
  input logic [REG_W-1:0]   scsi_stat1,
  input logic [REG_W-1:0]   dma_stat,
  input logic               scsi_pend,
  input logic               dma_pend,
  input logic               irq_n,
  input logic               halt_req
);
  logic rd_any;
  int unsigned since_rd;
  assign rd_any = rd_scsi0 | rd_scsi1 | rd_dma;

  always_ff @(posedge clk) begin
    if (!rst_n)                       since_rd <= GAP_CYCLES + 1;
    else if (rd_any)                  since_rd <= 1;
    else if (since_rd <= GAP_CYCLES)  since_rd <= since_rd + 1;
  end

  // R10
  gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rd >= 1 && since_rd <= GAP_CYCLES) |-> irq_n);

  // R6
  no_late_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_any) |=> !irq_n);

  // R4
  fatal_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dma_evt & DMA_FATAL)) || (|(scsi_evt & SCSI_FATAL))) |=> halt_req);

  // R7
  stack_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pend && !rd_dma) |=>
      ((dma_stat & ~$past(dma_stat) & ~$past(dma_evt & dma_mask & ~DMA_FATAL)) == '0));

  // R3
  quiet_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_pend && !rd_dma && dma_evt != '0 &&
     (dma_evt & ~(dma_mask & ~DMA_FATAL)) == '0) |=> !dma_pend);

  // R11
  split_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_scsi0 || rd_scsi1) && scsi_evt == '0 && !scsi_pend) |=>
      (scsi_stat0 == '0 && scsi_stat1 == '0));
endmodule

bind stk_irq_ctrl stk_irq_ctrl_chk #(
  .REG_W(REG_W), .SCSI_FATAL(SCSI_FATAL), .DMA_FATAL(DMA_FATAL), .GAP_CYCLES(GAP_CYCLES)
) chk_i (.*);

// File: tb/stk_irq_ctrl_tb_top.sv
module stk_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] scsi_evt, scsi_mask;
  logic [7:0]  dma_evt, dma_mask;
  logic        rd_scsi0, rd_scsi1, rd_dma;
  logic [7:0]  scsi_stat0, scsi_stat1, dma_stat;
  logic        scsi_pend, dma_pend, irq_n, halt_req;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  stk_irq_ctrl dut_i (.*);

  // row: evt[27:20] mask[19:12] rd[11] stat[10:3] pend[2] irq_n[1] halt[0]
  localparam int NROW = 22;
  localparam logic [27:0] VEC [NROW] = '{
    {8'h02, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0},
    {8'h10, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0},
    {8'h20, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0},
    {8'h00, 8'hFF, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0},
    {8'h00, 8'h00, 1'b1, 8'h30, 1'b1, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 8'h30, 1'b1, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 8'h30, 1'b1, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0},
    {8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h40, 8'h40, 1'b0, 8'h40, 1'b0, 1'b1, 1'b0},
    {8'h80, 8'h00, 1'b0, 8'hC0, 1'b1, 1'b0, 1'b0},
    {8'h01, 8'h01, 1'b0, 8'hC0, 1'b1, 1'b0, 1'b1},
    {8'h02, 8'h00, 1'b1, 8'h03, 1'b1, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 8'h03, 1'b1, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 8'h03, 1'b1, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 8'h03, 1'b1, 1'b0, 1'b1},
    {8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h04, 8'h04, 1'b0, 8'h04, 1'b1, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}
  };

  function automatic string row_req(input int i);
    case (i)
      0: return "R2";   1: return "R7";   2: return "R8";   3: return "R6";
      4: return "R9";   8: return "R9";   12: return "R3";  13: return "R3";
      14: return "R4";  15: return "R12"; 19: return "R5";  20: return "R4";
      21: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    scsi_evt = '0; scsi_mask = '0; dma_evt = '0; dma_mask = '0;
    rd_scsi0 = 1'b0; rd_scsi1 = 1'b0; rd_dma = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(20 * 10000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "dma_stat", 16'(dma_stat), 16'h0);
    chk("R1", "scsi_stat", {scsi_stat1, scsi_stat0}, 16'h0);
    chk("R1", "pend", {14'h0, scsi_pend, dma_pend}, 16'h0);
    chk("R1", "irq_n", 16'(irq_n), 16'h1);
    chk("R1", "halt_req", 16'(halt_req), 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      dma_evt  = VEC[i][27:20];
      dma_mask = VEC[i][19:12];
      rd_dma   = VEC[i][11];
      @(negedge clk);
      chk(row_req(i), $sformatf("row %0d dma_stat", i), 16'(dma_stat), 16'(VEC[i][10:3]));
      chk(row_req(i), $sformatf("row %0d dma_pend", i), 16'(dma_pend), 16'(VEC[i][2]));
      chk(row_req(i), $sformatf("row %0d irq_n", i), 16'(irq_n), 16'(VEC[i][1]));
      chk(row_req(i), $sformatf("row %0d halt_req", i), 16'(halt_req), 16'(VEC[i][0]));
    end
    idle_inputs();
    repeat (4) @(negedge clk);

    // bus-phase source: fatal bit 8 in the high register
    scsi_evt = 16'h0100;
    @(negedge clk);
    chk("R2", "scsi_stat1", 16'(scsi_stat1), 16'h01);
    chk("R2", "scsi_pend", 16'(scsi_pend), 16'h1);
    chk("R2", "irq_n", 16'(irq_n), 16'h0);
    chk("R4", "halt_req", 16'(halt_req), 16'h1);
    scsi_evt = 16'h0010;
    @(negedge clk);
    chk("R7", "scsi_stat0 stacked", 16'(scsi_stat0), 16'h00);
    scsi_evt = '0; rd_scsi1 = 1'b1;
    @(negedge clk);
    rd_scsi1 = 1'b0;
    chk("R11", "scsi_stat0 promoted", 16'(scsi_stat0), 16'h10);
    chk("R11", "scsi_stat1 cleared", 16'(scsi_stat1), 16'h00);
    chk("R5", "halt released", 16'(halt_req), 16'h0);
    chk("R10", "irq_n gap", 16'(irq_n), 16'h1);
    @(negedge clk);
    chk("R10", "irq_n gap 2", 16'(irq_n), 16'h1);
    @(negedge clk);
    chk("R10", "irq_n gap 3", 16'(irq_n), 16'h1);
    @(negedge clk);
    chk("R10", "irq_n reassert", 16'(irq_n), 16'h0);
    rd_scsi0 = 1'b1;
    @(negedge clk);
    rd_scsi0 = 1'b0;
    chk("R11", "scsi_stat0 after low read", 16'(scsi_stat0), 16'h00);
    chk("R9", "scsi_pend empty", 16'(scsi_pend), 16'h0);

    // R1 reset mid-run clears pending state
    dma_evt = 8'h02;
    @(negedge clk);
    dma_evt = '0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "dma_stat after reset", 16'(dma_stat), 16'h0);
    chk("R1", "irq_n after reset", 16'(irq_n), 16'h1);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule